// File: doc/BRIEF.md
# Conditional Branch Decision Unit

This block decides, for an 8-bit accumulator-style processor, whether a relative branch is taken. It also forms the program counter that follows. The processor presents a 4-bit condition select, the five condition-code flags (half-carry, interrupt mask, negative, zero, carry), the level of the external interrupt request pin, the address that follows the branch instruction and the signed offset byte. The block answers in the same cycle with a taken flag and the 16-bit next program counter.

The select code has two fields. Bits 3:1 choose one of eight base conditions. Bit 0 inverts that base condition, so every test and its complement share one piece of logic. The interrupt request pin is asynchronous to the core clock. It passes through a synchronizer chain (two flops by default) before any condition can use it. Every other input acts combinationally. The block contains no sequencing state, so it has no state machine. Its only storage is the synchronizer chain, which reset loads with the idle (high) pin level.

Top module: `cbu_branch_unit`

## Requirements
- R1: While `rst_n` is low, the synchronized pin level reads as high. With select 0xE (branch if pin high), `taken` is 1 during reset whatever level `irq_pin` has.
- R2: When the selected condition is false, `taken` is 0 and `next_pc` equals `fall_pc`.
- R3: When the selected condition is true, `taken` is 1 and `next_pc` equals `fall_pc` plus the sign-extended `offset`, taken modulo 2^16. Wrapping past 0xFFFF or below 0x0000 raises no fault.
- R4: Select 0x0 is always taken. Select 0x1 is never taken, and its `offset` has no effect on `next_pc`.
- R5: For every base condition, the select code with bit 0 set produces the inverse of `taken` from the same code with bit 0 clear, under identical inputs.
- R6: Select 0x2 (unsigned higher) is taken when carry and zero are both 0. Select 0x3 (lower or same) is taken when carry or zero is 1.
- R7: Select 0x4 (carry clear, also higher-or-same) is taken when carry is 0, and select 0x5 (carry set, also lower) is taken when carry is 1. Select 0x6 (not equal) is taken when zero is 0, and select 0x7 (equal) is taken when zero is 1.
- R8: Selects 0x8 and 0x9 test half-carry clear and set. Selects 0xA and 0xB test negative clear and set (plus and minus). Selects 0xC and 0xD test the interrupt mask clear and set.
- R9: Select 0xE is taken when the pin is high and select 0xF when it is low. The pin level in use is the one sampled two rising clock edges earlier. After one edge, the previous level still applies.
- R10: The offset reaches from -128 (0x80) to +127 (0x7F) relative to `fall_pc`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sel | input | 4 | Condition select; bits 3:1 base test, bit 0 inverts |
| flag_h | input | 1 | Half-carry flag |
| flag_i | input | 1 | Interrupt mask flag |
| flag_n | input | 1 | Negative flag |
| flag_z | input | 1 | Zero flag |
| flag_c | input | 1 | Carry flag |
| irq_pin | input | 1 | Asynchronous interrupt request pin level |
| fall_pc | input | 16 | Address following the branch instruction |
| offset | input | 8 | Signed two's-complement branch offset |
| taken | output | 1 | Branch decision |
| next_pc | output | 16 | Program counter to load next |

## Verification
The hardest situation to reach is a pin-based branch at the moment the pin has just changed. The answer must still follow the old level after one edge and switch only after the second. The stimulus drives a pin edge with select 0xE held, checks the output after each of the two following edges, and repeats with select 0xF. In the random sweep, the pin is held for two edges before each check so the expected level is known. Offsets of +127 and -128 are also applied next to 0x0000 and 0xFFFF, so that the wrap happens in both directions.

// File: rtl/cbu_pkg.sv
package cbu_pkg;

    typedef enum logic [2:0] {
        BASE_ALWAYS  = 3'd0,
        BASE_HIGHER  = 3'd1,
        BASE_C_CLEAR = 3'd2,
        BASE_Z_CLEAR = 3'd3,
        BASE_H_CLEAR = 3'd4,
        BASE_N_CLEAR = 3'd5,
        BASE_I_CLEAR = 3'd6,
        BASE_PIN_HI  = 3'd7
    } cond_base_e;

    typedef struct packed {
        logic h;
        logic i;
        logic n;
        logic z;
        logic c;
    } ccr_flags_t;

endpackage

// File: rtl/cbu_pin_sync.sv
module cbu_pin_sync #(
    parameter int  STAGES    = 2,
    parameter logic IDLE_LVL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_async,
    output logic pin_sync
);
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[0] <= IDLE_LVL;
                    else        chain_q[0] <= pin_async;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (!rst_n) chain_q[s] <= IDLE_LVL;
                    else        chain_q[s] <= chain_q[s-1];
                end
            end
        end
    endgenerate

    assign pin_sync = chain_q[STAGES-1];
endmodule

// File: rtl/cbu_cond_eval.sv
module cbu_cond_eval
    import cbu_pkg::*;
#(
    parameter int SEL_W = 4
) (
    input  logic [SEL_W-1:0] sel,
    input  ccr_flags_t       flags,
    input  logic             pin_lvl,
    output logic             cond_true
);
    cond_base_e base;
    logic       base_hit;

    assign base = cond_base_e'(sel[SEL_W-1:1]);

    always_comb begin
        unique case (base)
            BASE_ALWAYS:  base_hit = 1'b1;
            BASE_HIGHER:  base_hit = ~(flags.c | flags.z);
            BASE_C_CLEAR: base_hit = ~flags.c;
            BASE_Z_CLEAR: base_hit = ~flags.z;
            BASE_H_CLEAR: base_hit = ~flags.h;
            BASE_N_CLEAR: base_hit = ~flags.n;
            BASE_I_CLEAR: base_hit = ~flags.i;
            BASE_PIN_HI:  base_hit = pin_lvl;
            default:      base_hit = 1'b0;
        endcase
    end

    assign cond_true = base_hit ^ sel[0];
endmodule

// File: rtl/cbu_target_add.sv
module cbu_target_add #(
    parameter int ADDR_W = 16,
    parameter int OFS_W  = 8
) (
    input  logic [ADDR_W-1:0] base_pc,
    input  logic [OFS_W-1:0]  ofs,
    output logic [ADDR_W-1:0] target
);
    localparam int EXT_W = ADDR_W - OFS_W;

    logic [ADDR_W-1:0] ofs_ext;

    assign ofs_ext = {{EXT_W{ofs[OFS_W-1]}}, ofs};
    assign target  = base_pc + ofs_ext;
endmodule

// File: rtl/cbu_branch_unit.sv
module cbu_branch_unit
    import cbu_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int OFS_W       = 8,
    parameter int SEL_W       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEL_W-1:0]  sel,
    input  logic              flag_h,
    input  logic              flag_i,
    input  logic              flag_n,
    input  logic              flag_z,
    input  logic              flag_c,
    input  logic              irq_pin,
    input  logic [ADDR_W-1:0] fall_pc,
    input  logic [OFS_W-1:0]  offset,
    output logic              taken,
    output logic [ADDR_W-1:0] next_pc
);
    ccr_flags_t        flags;
    logic              pin_lvl;
    logic              cond_true;
    logic [ADDR_W-1:0] target;

    assign flags = '{h: flag_h, i: flag_i, n: flag_n, z: flag_z, c: flag_c};

    cbu_pin_sync #(
        .STAGES   (SYNC_STAGES),
        .IDLE_LVL (1'b1)
    ) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_async (irq_pin),
        .pin_sync  (pin_lvl)
    );

    cbu_cond_eval #(
        .SEL_W (SEL_W)
    ) u_eval (
        .sel       (sel),
        .flags     (flags),
        .pin_lvl   (pin_lvl),
        .cond_true (cond_true)
    );

    cbu_target_add #(
        .ADDR_W (ADDR_W),
        .OFS_W  (OFS_W)
    ) u_add (
        .base_pc (fall_pc),
        .ofs     (offset),
        .target  (target)
    );

    always_comb begin
        taken   = cond_true;
        next_pc = cond_true ? target : fall_pc;
    end
endmodule

// File: rtl/cbu_checker.sv
module cbu_checker #(
    parameter int ADDR_W      = 16,
    parameter int OFS_W       = 8,
    parameter int SEL_W       = 4,
    parameter int SYNC_STAGES = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [SEL_W-1:0]  sel,
    input logic              flag_c,
    input logic              flag_z,
    input logic              irq_pin,
    input logic [ADDR_W-1:0] fall_pc,
    input logic [OFS_W-1:0]  offset,
    input logic              taken,
    input logic [ADDR_W-1:0] next_pc
);
    logic [1:0] run_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)              run_cnt <= 2'd0;
        else if (run_cnt != 2'd2) run_cnt <= run_cnt + 2'd1;
    end

    p_fall_through_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !taken |-> next_pc == fall_pc);

    p_target_r3: assert property (@(posedge clk) disable iff (!rst_n)
        taken |-> next_pc == ADDR_W'(fall_pc + {{(ADDR_W-OFS_W){offset[OFS_W-1]}}, offset}));

    p_always_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sel == SEL_W'(0) |-> taken);

    p_never_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sel == SEL_W'(1) |-> !taken);

    p_higher_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sel == SEL_W'(2) |-> taken == !(flag_c || flag_z));

    p_equal_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sel == SEL_W'(7) |-> taken == flag_z);

    generate
        if (SYNC_STAGES == 2) begin : g_pin_chk
            p_pin_hi_r9: assert property (@(posedge clk) disable iff (!rst_n)
                (run_cnt == 2'd2 && sel == SEL_W'(14)) |-> taken == $past(irq_pin, 2));
        end
    endgenerate
endmodule

bind cbu_branch_unit cbu_checker #(
    .ADDR_W      (ADDR_W),
    .OFS_W       (OFS_W),
    .SEL_W       (SEL_W),
    .SYNC_STAGES (SYNC_STAGES)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel     (sel),
    .flag_c  (flag_c),
    .flag_z  (flag_z),
    .irq_pin (irq_pin),
    .fall_pc (fall_pc),
    .offset  (offset),
    .taken   (taken),
    .next_pc (next_pc)
);

// File: tb/sim_cbu_branch_unit.sv
module sim_cbu_branch_unit;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  sel = 4'h0;
    logic        flag_h = 0, flag_i = 0, flag_n = 0, flag_z = 0, flag_c = 0;
    logic        irq_pin = 1'b0;
    logic [15:0] fall_pc = 16'h0;
    logic [7:0]  offset = 8'h0;
    logic        taken;
    logic [15:0] next_pc;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cbu_branch_unit u0 (
        .clk(clk), .rst_n(rst_n), .sel(sel),
        .flag_h(flag_h), .flag_i(flag_i), .flag_n(flag_n),
        .flag_z(flag_z), .flag_c(flag_c), .irq_pin(irq_pin),
        .fall_pc(fall_pc), .offset(offset),
        .taken(taken), .next_pc(next_pc)
    );

    function automatic logic exp_taken(input logic [3:0] s, input logic h, input logic i,
                                       input logic n, input logic z, input logic c,
                                       input logic pin);
        logic b;
        case (s[3:1])
            3'd0: b = 1'b1;
            3'd1: b = !(c || z);
            3'd2: b = !c;
            3'd3: b = !z;
            3'd4: b = !h;
            3'd5: b = !n;
            3'd6: b = !i;
            default: b = pin;
        endcase
        return s[0] ? !b : b;
    endfunction

    function automatic logic [15:0] exp_pc(input logic t, input logic [15:0] pc,
                                           input logic [7:0] o);
        int signed so;
        so = int'(signed'(o));
        return t ? 16'(int'(pc) + so) : pc;
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_all(input string req, input logic pin);
        logic t;
        t = exp_taken(sel, flag_h, flag_i, flag_n, flag_z, flag_c, pin);
        check({req, " taken"}, {15'd0, taken}, {15'd0, t});
        check({req, " next_pc"}, next_pc, exp_pc(t, fall_pc, offset));
    endtask

    task automatic step;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic finish_run;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_fail++;
            n_checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        logic t_plain;
        void'($urandom(32'd1234));
        @(negedge clk);
        // R1: reset loads idle-high pin level
        sel = 4'hE; irq_pin = 1'b0; fall_pc = 16'h1000; offset = 8'h10;
        step(); step();
        #1 check("R1 reset pin-high taken", {15'd0, taken}, 16'd1);
        check("R1 reset next_pc", next_pc, 16'h1010);
        rst_n = 1'b1;

        // R4: always / never
        sel = 4'h0; fall_pc = 16'h2000; offset = 8'h05; #1;
        check("R4 always taken", {15'd0, taken}, 16'd1);
        check("R4 always pc", next_pc, 16'h2005);
        sel = 4'h1; offset = 8'h7F; #1;
        check("R4 never taken", {15'd0, taken}, 16'd0);
        check("R4 never ignores offset", next_pc, 16'h2000);

        // R10 / R3: reach and wrap
        sel = 4'h0; fall_pc = 16'hFFF0; offset = 8'h7F; #1;
        check("R10 +127 wrap high (R3)", next_pc, 16'h006F);
        fall_pc = 16'h0010; offset = 8'h80; #1;
        check("R10 -128 wrap low (R3)", next_pc, 16'hFF90);
        fall_pc = 16'h8000; offset = 8'h80; #1;
        check("R10 -128", next_pc, 16'h7F80);
        offset = 8'hFF; #1;
        check("R10 -1", next_pc, 16'h7FFF);

        // R6 boundaries
        sel = 4'h2; flag_c = 0; flag_z = 0; #1;
        check("R6 higher c0z0", {15'd0, taken}, 16'd1);
        flag_z = 1; #1;
        check("R6 higher z1", {15'd0, taken}, 16'd0);
        sel = 4'h3; flag_z = 0; flag_c = 1; #1;
        check("R6 lower-same c1", {15'd0, taken}, 16'd1);
        flag_c = 0; #1;
        check("R2 lower-same false pc", next_pc, fall_pc);

        // R9: pin edge latency
        sel = 4'hE; irq_pin = 1'b1; step(); step(); #1;
        check("R9 pin high settled", {15'd0, taken}, 16'd1);
        irq_pin = 1'b0; step(); #1;
        check("R9 one edge old level", {15'd0, taken}, 16'd1);
        step(); #1;
        check("R9 two edges new level", {15'd0, taken}, 16'd0);
        sel = 4'hF; #1;
        check("R9 pin low taken", {15'd0, taken}, 16'd1);
        irq_pin = 1'b1; step(); #1;
        check("R9 low still after one edge", {15'd0, taken}, 16'd1);
        step(); #1;
        check("R9 low cleared after two", {15'd0, taken}, 16'd0);

        // Random sweep: R2 R3 R5 R7 R8 R9
        for (int k = 0; k < 800; k++) begin
            logic pin_now;
            pin_now = 1'($urandom);
            irq_pin = pin_now;
            step(); step();
            for (int s = 0; s < 16; s++) begin
                sel = 4'(s);
                {flag_h, flag_i, flag_n, flag_z, flag_c} = 5'($urandom);
                fall_pc = 16'($urandom);
                offset = 8'($urandom);
                if (k % 50 == 0) offset = (s % 2 == 0) ? 8'h7F : 8'h80;
                #1;
                if (s >= 8) check_all("R8/R9 sweep", pin_now);
                else if (s >= 4) check_all("R7 sweep", pin_now);
                else check_all("R2/R3 sweep", pin_now);
                // R5: same inputs, bit 0 toggled gives inverse
                t_plain = taken;
                sel = sel ^ 4'h1; #1;
                check("R5 inversion", {15'd0, taken}, {15'd0, !t_plain});
            end
        end

        done = 1;
        finish_run();
    end
endmodule